// File: doc/BRIEF.md
# Keyed Watchdog Timer with Lock

This block is a watchdog timer reached through a plain 32-bit register port. One free-running count, measured from the last restart, drives two events. The first is an early-warning interrupt. The second, later event is a system reset request. Each event has its own power-of-two timeout. A timeout code `c` in the range 0..15 gives a period of 2^(25-c) clock cycles. Code 0 is therefore the longest period and code 15 (1024 cycles) the shortest.

Software keeps the system alive by writing a two-byte key pair to the feed register. A stray write cannot restart the count. Two further key values close and open the control register to writes, so a runaway program cannot quietly turn the timer off. A sleep indication enters as an input. While sleep is high, the count stops unless a control bit lets it keep running.

Top module: `keyed_wdog`

## Requirements
- R1: Reads return register state at these byte addresses: control at 0x00 (bits [10:0]), feed at 0x04 (reads 0), flags at 0x08, enables at 0x0C, a reserved word at 0x10 (reads 0), and lock status at 0x14 (bit 0). Flags and enables both use bit 0 for the interrupt event and bit 2 for the reset event.
- R2: Control bits [3:0] hold the interrupt code and bits [7:4] hold the reset code. Each event's period is 2^(25-code) cycles. An event's flag sets on the clock edge where the count, started from zero at the last restart, advances to that period.
- R3: The count advances only when control bit 8 (timer on) and bit 9 (count clock on) are both 1. Otherwise it holds its value.
- R4: The count restarts only when a feed write of 0xA5 is followed directly by a feed write of 0x5A. Any other feed write after 0xA5 cancels the pair. A write of 0xA5 always arms a new pair.
- R5: A lock-register write with low byte 0x24 locks the control register, and 0x42 unlocks it. Other values leave the lock state as it is. While locked, control writes are ignored. The lock status reads 1 when locked and 0 when unlocked.
- R6: While `sleep_i` is 1, the count advances only if control bit 10 is 1.
- R7: Each flag is cleared by writing 1 to its bit in the flags register.
- R8: `irq_o` is high exactly when the interrupt flag and the interrupt enable are both 1.
- R9: `rst_req_o` is a one-cycle pulse, produced on the edge where the reset flag sets, and only if the reset enable is 1. The reset flag sets whether or not the enable is 1.
- R10: A control write that changes either timeout code sets the count to zero. A control write that keeps both codes does not restart the count.
- R11: After reset, control, flags, enables and lock state are all 0, and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sleep_i | input | 1 | Sleep indication |
| irq_o | output | 1 | Early-warning interrupt level |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
A write takes effect on the edge at which its strobe is sampled. The new register value can therefore be read one cycle later, and read data is combinational from the address. Counted from the restart edge, a flag and its `rst_req_o` pulse appear exactly one period of edges later, and `irq_o` follows the flag in the same cycle. The bench keeps a behavioural model that advances on the same edge as the design. It compares both event outputs at every falling edge, and it reads registers one time step after it sets the address on a falling edge. This keeps every comparison half a cycle clear of the edge that produced the value.

// File: rtl/wdog_pkg.sv
// wdog_pkg: addresses, key bytes and the control word layout shared by the
// watchdog modules. Assumes byte addressing of 32-bit words.
package wdog_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_FEED = 5'h04;
    localparam logic [ADDR_W-1:0] A_FLAG = 5'h08;
    localparam logic [ADDR_W-1:0] A_EVEN = 5'h0C;
    localparam logic [ADDR_W-1:0] A_RSVD = 5'h10;
    localparam logic [ADDR_W-1:0] A_LOCK = 5'h14;

    localparam logic [7:0] KEY_ARM    = 8'hA5;
    localparam logic [7:0] KEY_FIRE   = 8'h5A;
    localparam logic [7:0] KEY_CLOSE  = 8'h24;
    localparam logic [7:0] KEY_OPEN   = 8'h42;

    localparam int CTRL_W = 11;

    // Control word; field order fixes the bit positions software uses.
    typedef struct packed {
        logic       run_in_sleep;  // bit 10
        logic       cnt_clk_on;    // bit 9
        logic       timer_on;      // bit 8
        logic [3:0] rst_code;      // bits 7:4
        logic [3:0] irq_code;      // bits 3:0
    } wd_ctrl_t;
endpackage

// File: rtl/wdog_keyseq.sv
// wdog_keyseq: two-byte feed sequencer. An arm byte opens the pair and the
// fire byte on the very next feed write produces a one-cycle restart.
// Assumes wr_i is already qualified with the feed address.
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] key_i,
    output logic       feed_o
);
    logic armed_q;

    // Feed fires when the armed pair is completed by the fire byte.
    assign feed_o = wr_i && armed_q && (key_i == KEY_FIRE);

    // Arm on the arm byte, disarm on any other feed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_i) begin
            armed_q <= (key_i == KEY_ARM);
        end
    end

    p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i == KEY_ARM) |=> armed_q);
    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i != KEY_ARM) |=> !armed_q);
endmodule

// File: rtl/wdog_lock.sv
// wdog_lock: holds the control-write lock. A close key sets it, an open key
// clears it, and every other value leaves it alone. Assumes wr_i is already
// qualified with the lock address.
module wdog_lock
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] key_i,
    output logic       locked_o
);
    logic locked_q;

    // Track lock state from key writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (wr_i && key_i == KEY_CLOSE) begin
            locked_q <= 1'b1;
        end else if (wr_i && key_i == KEY_OPEN) begin
            locked_q <= 1'b0;
        end
    end

    assign locked_o = locked_q;

    p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i == KEY_CLOSE) |=> locked_o);
    p_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i != KEY_CLOSE && key_i != KEY_OPEN) |=> $stable(locked_o));
endmodule

// File: rtl/wdog_count.sv
// wdog_count: saturating up-counter with one threshold comparator per event.
// Period of event i is 2^(EXP_MAX - code_i). A hit is reported in the cycle
// whose edge moves the count onto the period. Assumes EXP_MAX >= 2^CODE_W-1.
module wdog_count #(
    parameter int EXP_MAX = 25,
    parameter int CODE_W  = 4,
    parameter int NEV     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  restart_i,
    input  logic [NEV*CODE_W-1:0] codes_i,
    output logic [NEV-1:0]        hit_o
);
    localparam int CNT_W = EXP_MAX + 1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             inc;

    assign inc     = run_i && !restart_i && (cnt_q != {CNT_W{1'b1}});
    assign cnt_nxt = cnt_q + ONE;

    // One period decoder and comparator per event.
    for (genvar i = 0; i < NEV; i++) begin : g_ev
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  period;
        assign code     = codes_i[i*CODE_W +: CODE_W];
        assign period   = ONE << (EXP_MAX - int'(code));
        assign hit_o[i] = inc && (cnt_nxt == period);
    end

    // Restart wins over counting; the count holds when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_nxt;
        end
    end

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_wdog.sv
// keyed_wdog: watchdog with a keyed feed, a keyed control lock, independent
// warning and reset timeouts, write-one-to-clear flags and event enables.
// Assumes single-cycle writes and combinational reads on a byte address.
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int EXP_MAX = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sleep_i,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int CODE_W = 4;
    localparam int NEV    = 2;

    wd_ctrl_t       ctrl_q;
    logic           irq_flag_q, rst_flag_q;
    logic           irq_en_q, rst_en_q;
    logic           rst_req_q;
    logic           locked;
    logic           feed;
    logic           ctrl_wr, code_chg, restart, run;
    logic [NEV-1:0] hit;
    logic [31:0]    unused_wdata_hi;

    assign unused_wdata_hi = {bus_wdata[31:CTRL_W], {CTRL_W{1'b0}}};

    wdog_keyseq u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_wr && bus_addr == A_FEED),
        .key_i  (bus_wdata[7:0]),
        .feed_o (feed)
    );

    wdog_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr && bus_addr == A_LOCK),
        .key_i    (bus_wdata[7:0]),
        .locked_o (locked)
    );

    // Control write gating, restart and run conditions.
    assign ctrl_wr  = bus_wr && bus_addr == A_CTRL && !locked;
    assign code_chg = ctrl_wr && (bus_wdata[7:0] != {ctrl_q.rst_code, ctrl_q.irq_code});
    assign restart  = feed || code_chg;
    assign run      = ctrl_q.timer_on && ctrl_q.cnt_clk_on &&
                      (!sleep_i || ctrl_q.run_in_sleep);

    wdog_count #(.EXP_MAX(EXP_MAX), .CODE_W(CODE_W), .NEV(NEV)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .codes_i   ({ctrl_q.rst_code, ctrl_q.irq_code}),
        .hit_o     (hit)
    );

    // Control register, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wd_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // Event enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            rst_en_q <= 1'b0;
        end else if (bus_wr && bus_addr == A_EVEN) begin
            irq_en_q <= bus_wdata[0];
            rst_en_q <= bus_wdata[2];
        end
    end

    // Flags: set on a threshold hit, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag_q <= 1'b0;
            rst_flag_q <= 1'b0;
        end else begin
            irq_flag_q <= hit[0] ||
                (irq_flag_q && !(bus_wr && bus_addr == A_FLAG && bus_wdata[0]));
            rst_flag_q <= hit[1] ||
                (rst_flag_q && !(bus_wr && bus_addr == A_FLAG && bus_wdata[2]));
        end
    end

    // Reset request pulse on the edge the reset flag sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= hit[1] && rst_en_q;
        end
    end

    assign irq_o     = irq_flag_q && irq_en_q;
    assign rst_req_o = rst_req_q;

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
            A_FLAG:  bus_rdata = {29'd0, rst_flag_q, 1'b0, irq_flag_q};
            A_EVEN:  bus_rdata = {29'd0, rst_en_q, 1'b0, irq_en_q};
            A_LOCK:  bus_rdata = {31'd0, locked};
            default: bus_rdata = '0;
        endcase
    end

    p_locked_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(ctrl_q));
    p_req_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> rst_flag_q);
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_q && !(bus_wr && bus_addr == A_EVEN)) |=> !irq_o);
endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sleep_i = 1'b0;
    logic        irq_o, rst_req_o;

    int checks = 0;
    int fails  = 0;

    keyed_wdog u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #4 clk = ~clk;

    // Behavioural reference model
    logic [10:0] m_ctrl;
    logic [2:0]  m_en, m_flag;
    bit          m_lock, m_armed, m_req;
    longint      m_cnt;
    bit          t_run, t_fd, t_chg, t_hi, t_hr;
    longint      t_pi, t_pr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_en = '0; m_flag = '0; m_lock = 0;
            m_armed = 0; m_req = 0; m_cnt = 0;
        end else begin
            t_run = m_ctrl[8] && m_ctrl[9] && (!sleep_i || m_ctrl[10]);
            t_pi  = longint'(1) << (25 - m_ctrl[3:0]);
            t_pr  = longint'(1) << (25 - m_ctrl[7:4]);
            t_fd = 0; t_chg = 0; t_hi = 0; t_hr = 0;
            if (bus_wr && bus_addr == 5'h04) begin
                if (bus_wdata[7:0] == 8'hA5) m_armed = 1;
                else begin
                    t_fd = m_armed && bus_wdata[7:0] == 8'h5A;
                    m_armed = 0;
                end
            end
            if (bus_wr && bus_addr == 5'h00 && !m_lock) begin
                t_chg = bus_wdata[7:0] != m_ctrl[7:0];
                m_ctrl = bus_wdata[10:0];
            end
            if (bus_wr && bus_addr == 5'h14) begin
                if (bus_wdata[7:0] == 8'h24) m_lock = 1;
                else if (bus_wdata[7:0] == 8'h42) m_lock = 0;
            end
            if (t_fd || t_chg) m_cnt = 0;
            else if (t_run) begin
                m_cnt++;
                t_hi = (m_cnt == t_pi);
                t_hr = (m_cnt == t_pr);
            end
            if (bus_wr && bus_addr == 5'h08) m_flag = m_flag & ~(bus_wdata[2:0] & 3'b101);
            if (t_hi) m_flag[0] = 1'b1;
            if (t_hr) m_flag[2] = 1'b1;
            m_req = t_hr && m_en[2];
            if (bus_wr && bus_addr == 5'h0C) m_en = bus_wdata[2:0] & 3'b101;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of both event outputs (R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 irq_o vs model", {31'd0, irq_o}, {31'd0, m_flag[0] & m_en[0]});
            chk("R9 rst_req_o vs model", {31'd0, rst_req_o}, {31'd0, m_req});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic feed();
        wr(5'h04, 32'hA5);
        wr(5'h04, 32'h5A);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R11, R1: reset values and map
        rd("R11 ctrl reset", 5'h00, 32'h0);
        rd("R11 flags reset", 5'h08, 32'h0);
        rd("R11 enables reset", 5'h0C, 32'h0);
        rd("R11 lock reset", 5'h14, 32'h0);
        rd("R1 reserved word", 5'h10, 32'h0);

        // R2: irq code 15 -> 1024, rst code 14 -> 2048
        wr(5'h0C, 32'h5);
        wr(5'h00, 32'h3EF);
        rd("R1 ctrl readback", 5'h00, 32'h3EF);
        rd("R1 enables readback", 5'h0C, 32'h5);
        idle(1010);
        chk("R2 irq not before period", {31'd0, irq_o}, 32'h0);
        idle(30);
        chk("R2 irq after period", {31'd0, irq_o}, 32'h1);
        rd("R2 flags after irq period", 5'h08, 32'h1);
        wr(5'h08, 32'h1);
        rd("R7 irq flag cleared", 5'h08, 32'h0);
        idle(1030);
        rd("R9 reset flag set", 5'h08, 32'h4);
        wr(5'h08, 32'h4);
        rd("R7 reset flag cleared", 5'h08, 32'h0);

        // R4: valid feeds keep the count low
        feed(); idle(900); feed(); idle(900);
        chk("R4 fed timer no irq", {31'd0, irq_o}, 32'h0);
        wr(5'h04, 32'hA5); wr(5'h04, 32'h00); wr(5'h04, 32'h5A);
        idle(200);
        chk("R4 broken pair does not restart", {31'd0, irq_o}, 32'h1);
        wr(5'h08, 32'h5);
        wr(5'h04, 32'hA5); wr(5'h04, 32'hA5); wr(5'h04, 32'h5A);
        idle(900);
        chk("R4 repeated arm then fire restarts", {31'd0, irq_o}, 32'h0);

        // R5: lock keys
        wr(5'h14, 32'h24);
        rd("R5 lock reads 1", 5'h14, 32'h1);
        wr(5'h00, 32'h0);
        rd("R5 ctrl write ignored", 5'h00, 32'h3EF);
        wr(5'h14, 32'h11);
        rd("R5 other key keeps lock", 5'h14, 32'h1);
        wr(5'h14, 32'h42);
        rd("R5 unlock reads 0", 5'h14, 32'h0);

        // R6: sleep gating
        feed(); wr(5'h08, 32'h5);
        sleep_i = 1'b1;
        idle(1500);
        chk("R6 sleep halts count", {31'd0, irq_o}, 32'h0);
        wr(5'h00, 32'h7EF);
        idle(1100);
        chk("R6 run-in-sleep counts", {31'd0, irq_o}, 32'h1);
        sleep_i = 1'b0;

        // R3: timer enable off holds the count
        wr(5'h00, 32'h2EF); wr(5'h08, 32'h5); feed();
        idle(1500);
        chk("R3 timer off no count", {31'd0, irq_o}, 32'h0);
        wr(5'h00, 32'h1EF);
        idle(1500);
        chk("R3 count clock off no count", {31'd0, irq_o}, 32'h0);
        wr(5'h00, 32'h3EF);

        // R10: code change restarts, period now 2048 for both
        feed(); wr(5'h08, 32'h5);
        idle(800);
        wr(5'h00, 32'h3EE);
        idle(800);
        chk("R10 code change restarted count", {31'd0, irq_o}, 32'h0);
        idle(1300);
        chk("R10 irq at new 2048 period", {31'd0, irq_o}, 32'h1);

        // R9: reset event disabled, flag still sets
        wr(5'h0C, 32'h1); wr(5'h08, 32'h5); feed();
        idle(2100);
        rd("R9 flag sets with enable off", 5'h08, 32'h5);

        // R8: enable off masks irq, flag kept
        wr(5'h0C, 32'h0);
        chk("R8 irq masked by enable", {31'd0, irq_o}, 32'h0);
        rd("R8 flag kept while masked", 5'h08, 32'h5);
        wr(5'h0C, 32'h1);
        chk("R8 irq returns with enable", {31'd0, irq_o}, 32'h1);

        idle(5);
        finish_run();
    end
endmodule